// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block is a 1 KB data cache with one line per index, placed between a processor load/store port and a slower memory. Each of its 32 lines holds 32 bytes of data, a tag and a valid flag. A read that finds its line returns the addressed 32-bit word in the same cycle. A read that misses holds the processor in a stall while the whole line is fetched over a block-wide refill port.

Stores are never held back waiting for memory. Every accepted store updates the cached line if it is present. It is also placed in a four-entry first-in first-out write buffer, which a separate valid/ready port drains to memory one word at a time. Because memory therefore always holds every store once the buffer is empty, a line can be replaced without being written back. A parameter decides what a store miss does. With allocation on, the line is fetched first and then written. With allocation off, the store only goes to memory.

Top module: `dm_wt_cache`

## Requirements
- R1: The address splits into bits 31:10 (tag), bits 9:5 (line index) and bits 4:0 (byte within line). `cpu_hit` is high for a request only when the indexed line is valid and its stored tag equals the request tag. Two blocks with the same index and different tags displace each other.
- R2: After reset no line is valid, so the first access to any address misses. While no request is made, `cpu_stall`, `mem_rd_req` and `mem_wr_valid` are low.
- R3: A read that hits returns the word selected by address bits 4:2 on `cpu_rdata` in the same cycle, with `cpu_stall` low.
- R4: A read miss raises `cpu_stall` and `mem_rd_req`, with `mem_rd_addr` set to the request address with bits 4:0 cleared. `mem_rd_req` stays high until `mem_rd_valid`. The returned line (word k at bits 32k+31:32k) is installed, and in the next cycle the held request hits and completes.
- R5: Each accepted store appears exactly once on the drain port, in acceptance order. It carries its word address (bits 1:0 zero), its write data and its byte strobes. A word leaves when `mem_wr_valid` and `mem_wr_ready` are both high.
- R6: `cpu_size` 0 stores one byte, 1 a halfword and 2 a full word. Addresses must be aligned to the size. `cpu_wdata` is lane-aligned: byte lane b is bits 8b+7:8b, and the strobe bits name the lanes written. A store hit merges only those lanes into the cached word.
- R7: The write buffer holds at most 4 stores. A store that arrives while it is full stalls until an entry drains.
- R8: With `WRITE_ALLOC`=1, a store miss fetches the line, writes it and leaves it valid. With `WRITE_ALLOC`=0, a store miss leaves the cache unchanged and only enters the buffer.
- R9: A line fetch is not requested while the write buffer holds a store to the same 32-byte block. `mem_rd_req` stays low until that store has drained.
- R10: A store completes in its first cycle, without waiting for the drain port, whenever the buffer is not full and no line fetch is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_req | input | 1 | Processor request, held until not stalled |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_size | input | 2 | Store size: 0 byte, 1 halfword, 2 word |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Lane-aligned store data |
| cpu_rdata | output | 32 | Word read from the line |
| cpu_hit | output | 1 | Request finds a valid line with matching tag |
| cpu_stall | output | 1 | Request not completing this cycle |
| mem_rd_req | output | 1 | Line fetch request |
| mem_rd_addr | output | 32 | Line-aligned fetch address |
| mem_rd_valid | input | 1 | Fetched line present on mem_rd_data |
| mem_rd_data | input | 256 | Whole fetched line |
| mem_wr_valid | output | 1 | Write buffer has a store to drain |
| mem_wr_ready | input | 1 | Memory accepts the drained store |
| mem_wr_addr | output | 32 | Word address of the drained store |
| mem_wr_data | output | 32 | Data of the drained store |
| mem_wr_strb | output | 4 | Byte strobes of the drained store |

## Verification
A wrong valid bit or tag shows up on `cpu_hit` during the first cycle of the next access to that index. A corrupted line word shows up on `cpu_rdata` at the next read hit to it. A fetch issued before the same-block store has drained returns stale data, which is visible on the read that caused the fetch. Buffer ordering or lost stores show up on the drain port within a few cycles, and the bench checks every drained word against the stores it accepted.

// File: rtl/wt_cache_pkg.sv
// Shared types and helpers for the write-through cache.
// Assumes a 32-bit byte address and a 32-bit processor word.
package wt_cache_pkg;

    localparam int WORD_W = 32;
    localparam int ADDR_W = 32;

    // One pending store in the write buffer.
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
        logic [3:0]        strb;
    } wb_entry_t;

    // Controller states.
    typedef enum logic {
        CS_LOOKUP = 1'b0,
        CS_REFILL = 1'b1
    } ctl_state_e;

    // Byte-lane mask of an aligned store of the given size.
    function automatic logic [3:0] lane_mask(input logic [1:0] size, input logic [1:0] off);
        logic [3:0] m;
        case (size)
            2'd0:    m = 4'b0001 << off;
            2'd1:    m = off[1] ? 4'b1100 : 4'b0011;
            default: m = 4'b1111;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/cache_store.sv
// Line storage: valid flags (reset), tags and line data (not reset).
// Assumes fill and store never occur in the same cycle; fill wins if they do.
module cache_store #(
    parameter int NUM_LINES = 32,
    parameter int LINE_W    = 256,
    parameter int TAG_W     = 22,
    parameter int IDX_W     = 5,
    parameter int WSEL_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    output logic              line_valid,
    output logic [TAG_W-1:0]  line_tag,
    output logic [LINE_W-1:0] line_data,
    input  logic              fill_en,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [LINE_W-1:0] fill_data,
    input  logic              wr_en,
    input  logic [WSEL_W-1:0] wr_word,
    input  logic [31:0]       wr_data,
    input  logic [3:0]        wr_strb
);

    logic [NUM_LINES-1:0] valid_q;
    logic [TAG_W-1:0]     tag_q  [NUM_LINES];
    logic [LINE_W-1:0]    data_q [NUM_LINES];

    assign line_valid = valid_q[idx];
    assign line_tag   = tag_q[idx];
    assign line_data  = data_q[idx];

    // Valid flags: cleared by reset, set by a fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (fill_en) begin
            valid_q[idx] <= 1'b1;
        end
    end

    // Tag written on fill.
    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[idx] <= fill_tag;
        end
    end

    // Line data: whole line on fill, strobed bytes of one word on a store hit.
    always_ff @(posedge clk) begin
        if (fill_en) begin
            data_q[idx] <= fill_data;
        end else if (wr_en) begin
            for (int b = 0; b < 4; b++) begin
                if (wr_strb[b]) begin
                    data_q[idx][int'(wr_word) * 32 + b * 8 +: 8] <= wr_data[b * 8 +: 8];
                end
            end
        end
    end

endmodule

// File: rtl/cache_wbuf.sv
// First-in first-out store buffer with a block-address probe.
// Assumes DEPTH is a power of two and push is never asserted while full.
module cache_wbuf
    import wt_cache_pkg::*;
#(
    parameter  int DEPTH = 4,
    parameter  int BLK_W = 27,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  wb_entry_t        push_ent,
    input  logic             pop,
    output wb_entry_t        head_ent,
    output logic             empty,
    output logic             full,
    output logic [CNT_W-1:0] count,
    input  logic [BLK_W-1:0] probe_blk,
    output logic             match
);

    wb_entry_t        ent_q [DEPTH];
    logic [DEPTH-1:0] occ_q;
    logic [PTR_W-1:0] wptr_q, rptr_q;
    logic [CNT_W-1:0] cnt_q;
    logic [DEPTH-1:0] hit_vec;

    assign head_ent = ent_q[rptr_q];
    assign count    = cnt_q;
    assign empty    = (cnt_q == '0);
    assign full     = (cnt_q == CNT_W'(DEPTH));

    // Per-entry block compare against the probe address.
    for (genvar i = 0; i < DEPTH; i++) begin : g_probe
        assign hit_vec[i] = occ_q[i] && (ent_q[i].addr[ADDR_W-1 -: BLK_W] == probe_blk);
    end
    assign match = |hit_vec;

    // Entry payload storage.
    always_ff @(posedge clk) begin
        if (push) begin
            ent_q[wptr_q] <= push_ent;
        end
    end

    // Pointers, occupancy flags and fill count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            occ_q  <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) begin
                wptr_q        <= wptr_q + PTR_W'(1);
                occ_q[wptr_q] <= 1'b1;
            end
            if (pop) begin
                rptr_q        <= rptr_q + PTR_W'(1);
                occ_q[rptr_q] <= 1'b0;
            end
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + CNT_W'(1);
                2'b01:   cnt_q <= cnt_q - CNT_W'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

endmodule

// File: rtl/cache_ctrl.sv
// Request sequencing: completes hits and buffered stores, runs line fetches.
// Assumes the processor holds its request unchanged while stalled.
module cache_ctrl
    import wt_cache_pkg::*;
#(
    parameter bit WRITE_ALLOC = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic we,
    input  logic line_hit,
    input  logic wb_full,
    input  logic wb_match,
    input  logic mem_rd_valid,
    output logic done,
    output logic fill_en,
    output logic mem_rd_req
);

    ctl_state_e state_q, state_d;
    logic       need_line;

    assign need_line = !line_hit && (!we || WRITE_ALLOC);

    // Next state and per-cycle outputs.
    always_comb begin
        state_d    = state_q;
        done       = 1'b0;
        fill_en    = 1'b0;
        mem_rd_req = 1'b0;
        case (state_q)
            CS_LOOKUP: begin
                if (req) begin
                    if (need_line) begin
                        state_d = CS_REFILL;
                    end else begin
                        done = we ? !wb_full : 1'b1;
                    end
                end
            end
            CS_REFILL: begin
                mem_rd_req = !wb_match;
                if (mem_rd_req && mem_rd_valid) begin
                    fill_en = 1'b1;
                    state_d = CS_LOOKUP;
                end
            end
            default: state_d = CS_LOOKUP;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CS_LOOKUP;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/dm_wt_cache.sv
// Direct-mapped write-through data cache with a drained store buffer.
// Assumes requests are held while stalled, and stores are aligned to size with lane-aligned data.
module dm_wt_cache
    import wt_cache_pkg::*;
#(
    parameter  int LINE_BYTES  = 32,
    parameter  int NUM_LINES   = 32,
    parameter  int WB_DEPTH    = 4,
    parameter  bit WRITE_ALLOC = 1'b1,
    localparam int LINE_W      = LINE_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [1:0]        cpu_size,
    input  logic [31:0]       cpu_addr,
    input  logic [31:0]       cpu_wdata,
    output logic [31:0]       cpu_rdata,
    output logic              cpu_hit,
    output logic              cpu_stall,
    output logic              mem_rd_req,
    output logic [31:0]       mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [LINE_W-1:0] mem_rd_data,
    output logic              mem_wr_valid,
    input  logic              mem_wr_ready,
    output logic [31:0]       mem_wr_addr,
    output logic [31:0]       mem_wr_data,
    output logic [3:0]        mem_wr_strb
);

    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(NUM_LINES);
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
    localparam int BLK_W  = ADDR_W - OFF_W;
    localparam int WORDS  = LINE_BYTES / 4;
    localparam int WSEL_W = $clog2(WORDS);
    localparam int CNT_W  = $clog2(WB_DEPTH + 1);

    logic [TAG_W-1:0]  a_tag;
    logic [IDX_W-1:0]  a_idx;
    logic [WSEL_W-1:0] a_word;
    logic              line_valid, line_hit;
    logic [TAG_W-1:0]  line_tag;
    logic [LINE_W-1:0] line_data;
    logic [31:0]       line_words [WORDS];
    logic              done, fill_en, st_write, wb_push, wb_pop;
    logic              wb_empty, wb_full, wb_match;
    logic [CNT_W-1:0]  wb_count;
    logic [3:0]        st_strb;
    wb_entry_t         push_ent, head_ent;

    // Address fields.
    assign a_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
    assign a_idx  = cpu_addr[OFF_W +: IDX_W];
    assign a_word = cpu_addr[2 +: WSEL_W];

    assign line_hit  = line_valid && (line_tag == a_tag);
    assign cpu_hit   = cpu_req && line_hit;
    assign cpu_stall = cpu_req && !done;

    // Word view of the selected line.
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        assign line_words[w] = line_data[w * 32 +: 32];
    end
    assign cpu_rdata = line_words[a_word];

    // Store path: cache update on hit, buffer entry for every accepted store.
    assign st_strb  = lane_mask(cpu_size, cpu_addr[1:0]);
    assign st_write = done && cpu_we && line_hit;
    assign wb_push  = done && cpu_we;
    assign wb_pop   = mem_wr_valid && mem_wr_ready;
    assign push_ent = '{addr: {cpu_addr[ADDR_W-1:2], 2'b00}, data: cpu_wdata, strb: st_strb};

    assign mem_rd_addr  = {cpu_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    assign mem_wr_valid = !wb_empty;
    assign mem_wr_addr  = head_ent.addr;
    assign mem_wr_data  = head_ent.data;
    assign mem_wr_strb  = head_ent.strb;

    cache_store #(
        .NUM_LINES(NUM_LINES), .LINE_W(LINE_W), .TAG_W(TAG_W),
        .IDX_W(IDX_W), .WSEL_W(WSEL_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .idx(a_idx),
        .line_valid(line_valid), .line_tag(line_tag), .line_data(line_data),
        .fill_en(fill_en), .fill_tag(a_tag), .fill_data(mem_rd_data),
        .wr_en(st_write), .wr_word(a_word), .wr_data(cpu_wdata), .wr_strb(st_strb)
    );

    cache_wbuf #(
        .DEPTH(WB_DEPTH), .BLK_W(BLK_W)
    ) u_wbuf (
        .clk(clk), .rst_n(rst_n), .push(wb_push), .push_ent(push_ent),
        .pop(wb_pop), .head_ent(head_ent), .empty(wb_empty), .full(wb_full),
        .count(wb_count), .probe_blk(cpu_addr[ADDR_W-1:OFF_W]), .match(wb_match)
    );

    cache_ctrl #(
        .WRITE_ALLOC(WRITE_ALLOC)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .req(cpu_req), .we(cpu_we), .line_hit(line_hit),
        .wb_full(wb_full), .wb_match(wb_match), .mem_rd_valid(mem_rd_valid),
        .done(done), .fill_en(fill_en), .mem_rd_req(mem_rd_req)
    );

endmodule

// File: rtl/wt_cache_checker.sv
// Temporal checks on the cache ports and its store buffer; bound into dm_wt_cache.
module wt_cache_checker #(
    parameter  int WB_DEPTH = 4,
    localparam int CNT_W    = $clog2(WB_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_req,
    input logic             cpu_we,
    input logic [31:0]      cpu_addr,
    input logic             cpu_hit,
    input logic             cpu_stall,
    input logic             mem_rd_req,
    input logic             mem_rd_valid,
    input logic             wb_full,
    input logic             wb_match,
    input logic [CNT_W-1:0] wb_count
);

    // R7: a store facing a full buffer does not complete.
    a_r7_full_store_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req && cpu_we && wb_full |-> cpu_stall);

    // R7: occupancy never exceeds the depth.
    a_r7_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(wb_count) <= WB_DEPTH);

    // R9: no fetch while a same-block store is pending.
    a_r9_no_fetch_over_pending: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> !wb_match);

    // R3: a read hit completes at once.
    a_r3_hit_read_free: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req && !cpu_we && cpu_hit |-> !cpu_stall);

    // R4: the fetch request holds until data returns.
    a_r4_fetch_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req && !mem_rd_valid |=> mem_rd_req);

    // R4: a held request hits right after its line is installed.
    a_r4_fill_gives_hit: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req && mem_rd_valid |=> (!cpu_req || !$stable(cpu_addr) || cpu_hit));

endmodule

bind dm_wt_cache wt_cache_checker #(.WB_DEPTH(WB_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_hit(cpu_hit), .cpu_stall(cpu_stall),
    .mem_rd_req(mem_rd_req), .mem_rd_valid(mem_rd_valid),
    .wb_full(wb_full), .wb_match(wb_match), .wb_count(wb_count)
);

// File: tb/tb_dm_wt_cache.sv
// Bench: directed corner cases plus seeded random loads and stores.
module tb_dm_wt_cache;

    localparam bit WA     = 1'b1;
    localparam int LINE_W = 256;
    localparam int MEMW   = 4096;
    localparam int QN     = 256;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cpu_req, cpu_we;
    logic [1:0]        cpu_size;
    logic [31:0]       cpu_addr, cpu_wdata, cpu_rdata;
    logic              cpu_hit, cpu_stall;
    logic              mem_rd_req, mem_rd_valid;
    logic [31:0]       mem_rd_addr;
    logic [LINE_W-1:0] mem_rd_data;
    logic              mem_wr_valid, mem_wr_ready;
    logic [31:0]       mem_wr_addr, mem_wr_data;
    logic [3:0]        mem_wr_strb;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int ready_mode = 1;
    int release_cyc = -1;
    int rcnt = 0;
    int qh = 0;
    int qt = 0;
    bit ended = 1'b0;

    logic [31:0] refmem [MEMW];
    logic [31:0] lowmem [MEMW];
    logic        mvalid [32];
    logic [21:0] mtag   [32];
    logic [31:0] q_addr [QN];
    logic [31:0] q_data [QN];
    logic [3:0]  q_strb [QN];

    always #4 clk = ~clk;

    dm_wt_cache #(.WRITE_ALLOC(WA)) dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_size(cpu_size), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_hit(cpu_hit), .cpu_stall(cpu_stall),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .mem_wr_strb(mem_wr_strb)
    );

    function automatic logic [3:0] strobe_of(input logic [1:0] sz, input logic [1:0] off);
        if (sz == 2'd0) return 4'b0001 << off;
        if (sz == 2'd1) return off[1] ? 4'b1100 : 4'b0011;
        return 4'b1111;
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] s);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++) if (s[b]) r[b*8 +: 8] = nw[b*8 +: 8];
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Drain-side ready pattern and cycle count.
    always @(negedge clk) begin
        cyc++;
        if (release_cyc == cyc) ready_mode = 1;
        mem_wr_ready = (ready_mode == 2) ? 1'($urandom % 2) : (ready_mode == 1);
    end

    // Line fetch model: three-cycle latency, data from lower memory.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rd_valid <= 1'b0;
            rcnt <= 0;
        end else if (mem_rd_valid) begin
            mem_rd_valid <= 1'b0;
        end else if (mem_rd_req) begin
            if (rcnt == 2) begin
                rcnt <= 0;
                mem_rd_valid <= 1'b1;
                for (int w = 0; w < 8; w++)
                    mem_rd_data[w*32 +: 32] <= lowmem[int'(mem_rd_addr[13:5]) * 8 + w];
            end else begin
                rcnt <= rcnt + 1;
            end
        end
    end

    // Drain model: compare with accepted stores in order (R5), then commit.
    always @(posedge clk) begin
        if (rst_n && mem_wr_valid && mem_wr_ready) begin
            if (qh == qt) begin
                check(1'b0, "R5 drain with nothing pending", mem_wr_addr, 32'h0);
            end else begin
                check(mem_wr_addr == q_addr[qh % QN] && mem_wr_data == q_data[qh % QN]
                      && mem_wr_strb == q_strb[qh % QN], "R5 drain order", mem_wr_addr, q_addr[qh % QN]);
                lowmem[mem_wr_addr[13:2]] = merge(lowmem[mem_wr_addr[13:2]], q_data[qh % QN], q_strb[qh % QN]);
                qh++;
            end
        end
    end

    // One processor access. chk: 1 no first-cycle stall, 2 first-cycle stall,
    // 3 watch fetch hold-off, 4 first access after reset, 5 merged read, 6 allocated line.
    task automatic do_op(input bit we, input logic [31:0] addr, input logic [1:0] sz,
                         input logic [31:0] wd, input int chk);
        int          idx = int'(addr[9:5]);
        logic [21:0] tg  = addr[31:10];
        bit          exp_hit = mvalid[idx] && (mtag[idx] == tg);
        logic [3:0]  s;
        string       lbl;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_size = sz; cpu_wdata = wd;
        #2;
        check(cpu_hit == exp_hit, "R1 hit flag", 32'(cpu_hit), 32'(exp_hit));
        if (chk == 4) check(!cpu_hit, "R2 first access misses", 32'(cpu_hit), 32'h0);
        if (chk == 6) check(cpu_hit == WA, "R8 store miss line state", 32'(cpu_hit), 32'(WA));
        if (chk == 1) check(!cpu_stall, "R10 store without waiting", 32'(cpu_stall), 32'h0);
        if (chk == 2) check(cpu_stall, "R7 full buffer stalls", 32'(cpu_stall), 32'h1);
        while (cpu_stall) begin
            if (chk == 3 && ready_mode == 0)
                check(!mem_rd_req, "R9 fetch held back", 32'(mem_rd_req), 32'h0);
            @(negedge clk);
            #2;
        end
        if (!we) begin
            lbl = (chk == 5) ? "R6 merged bytes" : (exp_hit ? "R3 read hit data" : "R4 read miss data");
            check(cpu_rdata == refmem[addr[13:2]], lbl, cpu_rdata, refmem[addr[13:2]]);
            mvalid[idx] = 1'b1;
            mtag[idx] = tg;
        end else begin
            s = strobe_of(sz, addr[1:0]);
            refmem[addr[13:2]] = merge(refmem[addr[13:2]], wd, s);
            q_addr[qt % QN] = {addr[31:2], 2'b00};
            q_data[qt % QN] = wd;
            q_strb[qt % QN] = s;
            qt++;
            if (!exp_hit && WA) begin
                mvalid[idx] = 1'b1;
                mtag[idx] = tg;
            end
        end
        @(posedge clk);
        #1 cpu_req = 1'b0;
    endtask

    task automatic wait_empty();
        while (qh != qt) @(posedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 32'(cyc), 32'h0);
        finish_run();
    end

    initial begin
        logic [31:0] a;
        logic [1:0]  sz;
        void'($urandom(32'd1234));
        rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_size = 2'd2;
        cpu_addr = '0; cpu_wdata = '0; mem_wr_ready = 1'b1;
        mem_rd_valid = 1'b0; mem_rd_data = '0;
        for (int i = 0; i < MEMW; i++) begin
            refmem[i] = (i * 32'h9E3779B1) ^ 32'h5A5A_0F0F;
            lowmem[i] = refmem[i];
        end
        for (int i = 0; i < 32; i++) begin
            mvalid[i] = 1'b0;
            mtag[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #2;
        check(!cpu_stall && !mem_rd_req && !mem_wr_valid, "R2 idle after reset",
              {29'h0, cpu_stall, mem_rd_req, mem_wr_valid}, 32'h0);

        // R2, R3, R4, R1: first miss, hit, conflict eviction, return.
        do_op(1'b0, 32'h100, 2'd2, 32'h0, 4);
        do_op(1'b0, 32'h104, 2'd2, 32'h0, 0);
        do_op(1'b0, 32'h500, 2'd2, 32'h0, 0);
        do_op(1'b0, 32'h108, 2'd2, 32'h0, 0);

        // R6: halfword and byte stores merged into a cached word.
        do_op(1'b1, 32'h10A, 2'd1, 32'hBEEF_0000, 0);
        do_op(1'b1, 32'h109, 2'd0, 32'h0000_7700, 0);
        do_op(1'b0, 32'h108, 2'd2, 32'h0, 5);

        // R8: store miss then read of the same line.
        do_op(1'b1, 32'h2A4, 2'd2, 32'hCAFE_1234, 0);
        do_op(1'b0, 32'h2A4, 2'd2, 32'h0, 6);

        // R10 and R7: four stores fill a blocked buffer, the fifth waits.
        wait_empty();
        ready_mode = 0;
        for (int i = 0; i < 4; i++)
            do_op(1'b1, 32'h100 + 32'(i * 4), 2'd2, 32'hA000_0000 + 32'(i), 1);
        release_cyc = cyc + 5;
        do_op(1'b1, 32'h110, 2'd2, 32'hA000_0004, 2);
        wait_empty();

        // R9: refetch of a block whose store is still buffered.
        do_op(1'b0, 32'h040, 2'd2, 32'h0, 0);
        ready_mode = 0;
        do_op(1'b1, 32'h044, 2'd2, 32'h1357_9BDF, 1);
        do_op(1'b0, 32'h440, 2'd2, 32'h0, 0);
        release_cyc = cyc + 8;
        do_op(1'b0, 32'h044, 2'd2, 32'h0, 3);

        // Random mix with a random drain pattern.
        ready_mode = 2;
        for (int n = 0; n < 600; n++) begin
            a = $urandom & 32'h3FFF;
            sz = 2'($urandom % 3);
            if (sz == 2'd2) a[1:0] = 2'b00;
            if (sz == 2'd1) a[0] = 1'b0;
            do_op(($urandom % 10) < 4, a, sz, $urandom, 0);
        end

        ready_mode = 1;
        wait_empty();
        repeat (2) @(posedge clk);
        #1;
        check(qh == qt && !mem_wr_valid, "R5 every store drained", 32'(qt - qh), 32'h0);
        finish_run();
    end

endmodule